// File: doc/BRIEF.md
# Oversampling Manchester Line Receiver

This block takes one Manchester-coded line, samples it with a free-running local clock that runs OVS times faster than the half-bit symbol rate, and recovers the data bits. A phase counter is reloaded on every line transition, and it fires a sample strobe about half a symbol later. Each sampled half-bit symbol goes into a two-deep history.

Bit framing is not taken from a preamble. Instead the receiver waits for three consecutive symbols of the form a, a, not-a. That shape can only end on a bit boundary, so its last two symbols are taken as one whole bit. A steady alternating stream fits both all-ones and all-zeros data, and it never produces this shape. From lock onward, every pair of symbols is decoded as one bit. A pair of two equal symbols is flagged as a code violation, and the search for a boundary starts over.

Top module: `manch_rx`

## Requirements
- R1: A data bit 0 is carried as a low symbol followed by a high symbol, and a 1 as high then low. Each decoded bit appears on `bit_o` in the cycle `bit_valid_o` is high.
- R2: The phase counter reloads on each synchronized line transition and samples the line OVS/2 clocks later. Without a transition it wraps every OVS clocks. Symbols stretched or shortened by one clock still decode correctly.
- R3: A stream of alternating symbols (all-ones data from the start of the stream) never sets `locked_o` and produces no `bit_valid_o`.
- R4: When the last three symbols are 0,0,1, lock is set and a bit of value 0 is output at once.
- R5: When the last three symbols are 1,1,0, lock is set and a bit of value 1 is output at once.
- R6: After lock, each later pair of symbols is decoded in arrival order. The bits 0,1,1,1,1,0,0,1 come back unchanged.
- R7: While locked, a pair of equal symbols raises `viol_o` for exactly one cycle, clears `locked_o` in that same cycle, and outputs no bit for that pair.
- R8: After a violation, the boundary search uses only symbols received after the violating pair.
- R9: A synchronous active-high reset clears the counter, the history and the lock. All outputs read 0 after reset.
- R10: `bit_valid_o` is never high for two consecutive cycles, and it is never high while unlocked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local oversampling clock |
| rst | input | 1 | Synchronous active-high reset |
| line_i | input | 1 | Asynchronous Manchester line |
| bit_o | output | 1 | Decoded data bit |
| bit_valid_o | output | 1 | One-cycle strobe marking a decoded bit |
| locked_o | output | 1 | Bit boundary found |
| viol_o | output | 1 | One-cycle code-violation pulse |

## Verification
Streams that start with 0 and streams that start with 1 show that the 1,1,0 and 0,0,1 shapes each fix framing at the right symbol. An all-ones alternating stream shows that ambiguous input is never framed. The eight-bit example is sent with symbol lengths alternating between OVS+1 and OVS-1 clocks, which tests re-centring on edges. A stream with an injected equal-symbol pair tells a clean drop and re-frame on fresh symbols apart from a relock built on stale history.

// File: rtl/manch_rx.sv
module manch_rx #(
  parameter int OVS = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic line_i,
  output logic bit_o,
  output logic bit_valid_o,
  output logic locked_o,
  output logic viol_o
);
  localparam int CW = $clog2(OVS);
  localparam logic [CW-1:0] MID = CW'(OVS / 2);
  localparam logic [CW-1:0] TOP = CW'(OVS - 1);

  logic [2:0]    sync_q;
  logic [CW-1:0] cnt;
  logic [1:0]    hist;
  logic [1:0]    hfill;
  logic          phase;

  wire lvl    = sync_q[1];
  wire tr     = sync_q[2] ^ sync_q[1];
  wire strobe = (cnt == MID) && !tr;
  wire framed = (hfill == 2'd2) && (hist[1] == hist[0]) && (hist[0] != lvl);

  always_ff @(posedge clk) sync_q <= {sync_q[1:0], line_i};

  always_ff @(posedge clk) begin
    if (rst)             cnt <= '0;
    else if (tr)         cnt <= CW'(1);
    else if (cnt == TOP) cnt <= '0;
    else                 cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hist        <= '0;
      hfill       <= '0;
      phase       <= 1'b0;
      locked_o    <= 1'b0;
      bit_o       <= 1'b0;
      bit_valid_o <= 1'b0;
      viol_o      <= 1'b0;
    end else begin
      bit_valid_o <= 1'b0;
      viol_o      <= 1'b0;
      if (strobe) begin
        hist <= {hist[0], lvl};
        if (hfill != 2'd2) hfill <= hfill + 1'b1;
        if (!locked_o) begin
          if (framed) begin
            locked_o    <= 1'b1;
            bit_o       <= hist[0];
            bit_valid_o <= 1'b1;
            phase       <= 1'b0;
          end
        end else if (!phase) begin
          phase <= 1'b1;
        end else begin
          phase <= 1'b0;
          if (hist[0] != lvl) begin
            bit_o       <= hist[0];
            bit_valid_o <= 1'b1;
          end else begin
            viol_o   <= 1'b1;
            locked_o <= 1'b0;
            hfill    <= '0;
          end
        end
      end
    end
  end

  assert_cnt_range_R2: assert property (@(posedge clk) disable iff (rst)
    cnt <= TOP);
  assert_valid_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    bit_valid_o |=> !bit_valid_o);
  assert_valid_locked_R10: assert property (@(posedge clk) disable iff (rst)
    bit_valid_o |-> locked_o);
  assert_viol_drop_R7: assert property (@(posedge clk) disable iff (rst)
    viol_o |-> (!locked_o && !bit_valid_o));
  assert_viol_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    viol_o |=> !viol_o);
  assert_lock_emits_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(locked_o) |-> bit_valid_o);
endmodule

// File: tb/manch_rx_tb.sv
module manch_rx_tb;
  localparam int OVS = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic line_i = 1'b0;
  logic bit_o, bit_valid_o, locked_o, viol_o;

  int checks = 0;
  int fails = 0;
  int viol_cnt = 0;
  bit mon_en = 1'b0;
  bit done = 1'b0;
  logic exp_q[$];

  always #4 clk = ~clk;

  manch_rx #(.OVS(OVS)) u_dut (
    .clk(clk), .rst(rst), .line_i(line_i),
    .bit_o(bit_o), .bit_valid_o(bit_valid_o),
    .locked_o(locked_o), .viol_o(viol_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic first_sym);
    mon_en = 1'b0;
    rst = 1'b1;
    line_i = first_sym;
    repeat (6) @(negedge clk);
    rst = 1'b0;
    exp_q.delete();
    viol_cnt = 0;
    mon_en = 1'b1;
  endtask

  task automatic send_sym(input logic v, input int len);
    line_i = v;
    repeat (len) @(negedge clk);
  endtask

  task automatic send_bits(input logic [31:0] bits, input int n, input bit jit);
    for (int i = n - 1; i >= 0; i--) begin
      send_sym(bits[i], jit ? OVS + 1 : OVS);
      send_sym(~bits[i], jit ? OVS - 1 : OVS);
    end
  endtask

  task automatic expect_bits(input logic [31:0] bits, input int n);
    for (int i = n - 1; i >= 0; i--) exp_q.push_back(bits[i]);
  endtask

  task automatic finish_case(input string req);
    repeat (OVS / 2 + 4) @(negedge clk);
    check(exp_q.size() == 0, req, exp_q.size(), 0);
    mon_en = 1'b0;
  endtask

  always @(negedge clk) begin
    if (mon_en && !rst) begin
      if (bit_valid_o) begin
        if (!locked_o) begin
          checks++; fails++;
          $display("FAIL R10 valid while unlocked actual=%0d expected=%0d", locked_o, 1);
        end
        if (exp_q.size() == 0) begin
          checks++; fails++;
          $display("FAIL R3/R6 unexpected bit actual=%0d expected=none", bit_o);
        end else begin
          logic e;
          e = exp_q.pop_front();
          check(bit_o == e, "R1/R6 decoded bit", bit_o, e);
        end
      end
      if (viol_o) begin
        viol_cnt++;
        check(!locked_o, "R7 lock cleared on violation", locked_o, 0);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    // R9 reset state
    rst = 1'b1;
    repeat (6) @(negedge clk);
    check(bit_o == 0, "R9 bit_o", bit_o, 0);
    check(bit_valid_o == 0, "R9 bit_valid_o", bit_valid_o, 0);
    check(locked_o == 0, "R9 locked_o", locked_o, 0);
    check(viol_o == 0, "R9 viol_o", viol_o, 0);

    // R5: stream starting with 0 frames on 1,1,0
    do_reset(1'b0);
    expect_bits(32'b100110, 6);
    send_bits(32'b0100110, 7, 1'b0);
    check(locked_o == 1, "R5 locked", locked_o, 1);
    finish_case("R5 all bits seen");

    // R4: stream starting with 1 frames on 0,0,1
    do_reset(1'b1);
    expect_bits(32'b0110, 4);
    send_bits(32'b10110, 5, 1'b0);
    check(locked_o == 1, "R4 locked", locked_o, 1);
    finish_case("R4 all bits seen");

    // R6 + R2: eight-bit example with jittered symbol lengths
    do_reset(1'b1);
    expect_bits(32'b01111001, 8);
    send_bits(32'b101111001, 9, 1'b1);
    finish_case("R6/R2 all bits seen");

    // R3: alternating stream never locks
    do_reset(1'b1);
    send_bits(32'hFFF, 12, 1'b0);
    check(locked_o == 0, "R3 no lock", locked_o, 0);
    finish_case("R3 no bits");

    // R7 + R8: violation then fresh framing
    do_reset(1'b1);
    expect_bits(32'b011, 3);
    send_bits(32'b1011, 4, 1'b0);
    check(locked_o == 1, "R7 locked before violation", locked_o, 1);
    send_sym(1'b0, OVS);
    send_sym(1'b0, OVS);
    repeat (4) @(negedge clk);
    check(viol_cnt == 1, "R7 one violation pulse", viol_cnt, 1);
    check(locked_o == 0, "R7 unlocked after violation", locked_o, 0);
    expect_bits(32'b010, 3);
    send_bits(32'b11010, 5, 1'b0);
    check(locked_o == 1, "R8 relocked", locked_o, 1);
    check(viol_cnt == 1, "R8 no extra violation", viol_cnt, 1);
    finish_case("R8 all bits seen");

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule